// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM of 256K bytes that has two chip enables of opposite polarity. A requester offers one transaction at a time through a valid/ready handshake: a write flag, an 18-bit byte address and, for writes, a data byte. The controller drives the memory's address, both enables, the write strobe, the output enable and a tri-stated byte bus. For reads it returns the fetched byte with a one-cycle strobe.

Every access window is counted in clock cycles. The counts come from a clock-period parameter and a set of minimum-time parameters in picoseconds. Each count is the ceiling of a time divided by the period, and never less than one. Writes are sized so that the overlap of both enables and the low write strobe covers every write minimum. Nothing is driven onto the bus while the memory might still be driving it. Between transactions the memory is kept deselected.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it: chip enable 1 high, chip enable 2 low, write and output enables high, bus drivers off, ready high, read strobe low.
- R2: In every cycle where ready is high, the memory is deselected (chip enable 1 high, chip enable 2 low) and the write and output enables are high.
- R3: A read drives both enables active with output enable low and write enable high for exactly N_RD cycles. The read strobe is high for one cycle, in the cycle after the last access cycle, and carries the byte the memory drove.
- R4: A write holds write enable low for exactly N_WR consecutive cycles. During that window both chip enables are active, output enable is high, and the drivers present the accepted byte.
- R5: The address pins change only on an edge where write enable was high in the cycle before, and they stay fixed while write enable is low.
- R6: Write enable and both chip enables go inactive on the same edge. The drivers and the data byte stay on for the one cycle after that edge and are off in the cycle after that.
- R7: After output enable rises, the drivers stay off for at least N_TURN cycles. A write requested in the read strobe cycle keeps write enable high for exactly N_TURN-1 cycles after it is accepted. With no recent read, write enable falls in the first cycle after acceptance.
- R8: A request is accepted only on an edge where both valid and ready are high. Ready is low for the rest of the transaction. Request fields that change after acceptance do not affect the address or data used.
- R9: Each count is max(1, ceil(t/CLK_PS)). N_RD uses the larger of the address access time (85 ns) and the output-enable access time (40 ns). N_WR uses the largest of write pulse (40 ns), address-to-end (85 ns) and data setup (35 ns). N_TURN uses the larger of output disable (30 ns) and deselect (35 ns). At 8 ns this gives 11, 11 and 5.
- R10: The drivers are never on in a cycle where output enable is low.
- R11: The full 18-bit accepted address appears on the address pins for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, can accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid, one cycle |
| mem_addr_o | output | 18 | Memory address pins |
| mem_ce1_n_o | output | 1 | Chip enable 1, active low |
| mem_ce2_o | output | 1 | Chip enable 2, active high |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_io | inout | 8 | Bidirectional data bus |
| mem_dq_oe_o | output | 1 | Controller drivers enabled |

## Verification
The bench requests a write in the same cycle that the read strobe appears. A controller without turnaround would switch its drivers on at once, while the memory is still releasing the bus. A bus model flags that overlap, and the write-enable delay must equal N_TURN-1 exactly. Each write checks the cycle after write enable rises: a design that drops its drivers or moves the address on the terminating edge would store a corrupted byte, and a read-back exposes it. Request fields are scrambled mid-access, so a design that samples them late writes to the wrong location. A never-written location is read to show that read data comes from the bus and not from a stale register.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_WAIT,
    ST_WR,
    ST_WR_END
  } st_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles covering t_ps, at least one
  function automatic int unsigned cyc_of(int unsigned t_ps, int unsigned per_ps);
    int unsigned c;
    c = (t_ps + per_ps - 1) / per_ps;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o,
  output logic         le1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (load_i)        cnt_o <= load_val_i;
    else if (cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
  end

  assign last_o = (cnt_o == W'(1));
  assign le1_o  = (cnt_o <= W'(1));

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_o == '0) |=> cnt_o == '0); // R9
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD  = 11,
  parameter int unsigned N_WR  = 11,
  parameter int unsigned ACC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             acc_last_i,
  input  logic             turn_clear_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             acc_load_o,
  output logic [ACC_W-1:0] acc_val_o,
  output logic             turn_load_o,
  output logic             ce_o,
  output logic             we_o,
  output logic             oe_o,
  output logic             drv_o
);
  st_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    accept_o    = 1'b0;
    capture_o   = 1'b0;
    acc_load_o  = 1'b0;
    acc_val_o   = '0;
    turn_load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        if (!req_we_i) begin
          st_d       = ST_RD;
          acc_load_o = 1'b1;
          acc_val_o  = ACC_W'(N_RD);
        end else if (turn_clear_i) begin
          st_d       = ST_WR;
          acc_load_o = 1'b1;
          acc_val_o  = ACC_W'(N_WR);
        end else begin
          st_d = ST_WR_WAIT;
        end
      end
      ST_RD: if (acc_last_i) begin
        capture_o   = 1'b1;
        turn_load_o = 1'b1;
        st_d        = ST_IDLE;
      end
      ST_WR_WAIT: if (turn_clear_i) begin
        st_d       = ST_WR;
        acc_load_o = 1'b1;
        acc_val_o  = ACC_W'(N_WR);
      end
      ST_WR:     if (acc_last_i) st_d = ST_WR_END;
      ST_WR_END: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign ready_o = (st_q == ST_IDLE);

  // pins registered from next state: one clean edge per transition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ce_o  <= 1'b0;
      we_o  <= 1'b0;
      oe_o  <= 1'b0;
      drv_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      ce_o  <= (st_d == ST_RD) || (st_d == ST_WR);
      we_o  <= (st_d == ST_WR);
      oe_o  <= (st_d == ST_RD);
      drv_o <= (st_d == ST_WR) || (st_d == ST_WR_END);
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o); // R8
  AST_CAPTURE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> oe_o && ce_o); // R3
endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R3
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 18,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_PS    = 8000,
  parameter int unsigned T_AA_PS   = 85000,
  parameter int unsigned T_OE_PS   = 40000,
  parameter int unsigned T_WP_PS   = 40000,
  parameter int unsigned T_AW_PS   = 85000,
  parameter int unsigned T_DW_PS   = 35000,
  parameter int unsigned T_OHZ_PS  = 30000,
  parameter int unsigned T_CHZ_PS  = 35000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce1_n_o,
  output logic          mem_ce2_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  inout  wire  [DW-1:0] mem_dq_io,
  output logic          mem_dq_oe_o
);
  localparam int unsigned N_RD   = cyc_of(max2(T_AA_PS, T_OE_PS), CLK_PS);
  localparam int unsigned N_WR   = cyc_of(max2(max2(T_WP_PS, T_AW_PS), T_DW_PS), CLK_PS);
  localparam int unsigned N_TURN = cyc_of(max2(T_OHZ_PS, T_CHZ_PS), CLK_PS);
  localparam int unsigned ACC_W  = $clog2(max2(N_RD, N_WR) + 1);
  localparam int unsigned TRN_W  = $clog2(N_TURN + 1);

  logic             accept, capture, acc_load, turn_load;
  logic [ACC_W-1:0] acc_val, acc_cnt;
  logic [TRN_W-1:0] turn_cnt;
  logic             acc_last, acc_le1, turn_last, turn_le1;
  logic             ce, we, oe, drv;
  logic [DW-1:0]    wdata;

  sram_ctrl_seq #(.N_RD(N_RD), .N_WR(N_WR), .ACC_W(ACC_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i),
    .acc_last_i(acc_last), .turn_clear_i(turn_le1),
    .ready_o(req_ready_o), .accept_o(accept), .capture_o(capture),
    .acc_load_o(acc_load), .acc_val_o(acc_val), .turn_load_o(turn_load),
    .ce_o(ce), .we_o(we), .oe_o(oe), .drv_o(drv)
  );

  sram_ctrl_cnt #(.W(ACC_W)) u_acc_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc_load), .load_val_i(acc_val),
    .cnt_o(acc_cnt), .last_o(acc_last), .le1_o(acc_le1)
  );

  sram_ctrl_cnt #(.W(TRN_W)) u_turn_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(turn_load), .load_val_i(TRN_W'(N_TURN)),
    .cnt_o(turn_cnt), .last_o(turn_last), .le1_o(turn_le1)
  );

  sram_ctrl_io #(.AW(AW), .DW(DW)) u_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .capture_i(capture),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .dq_i(mem_dq_io),
    .addr_o(mem_addr_o), .wdata_o(wdata), .rdata_o(rd_data_o), .rvalid_o(rd_valid_o)
  );

  assign mem_ce1_n_o = ~ce;
  assign mem_ce2_o   = ce;
  assign mem_we_n_o  = ~we;
  assign mem_oe_n_o  = ~oe;
  assign mem_dq_oe_o = drv;

  for (genvar b = 0; b < DW; b++) begin : g_dq
    assign mem_dq_io[b] = drv ? wdata[b] : 1'bz;
  end

  // checker state: write-low length and bus-quiet gap
  localparam int unsigned WLC_W = $clog2(N_WR + 2);
  logic [WLC_W-1:0] we_low_cnt;
  logic [TRN_W-1:0] quiet_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt <= '0;
      quiet_cnt  <= TRN_W'(N_TURN);
    end else begin
      if (!mem_we_n_o) begin
        if (we_low_cnt != WLC_W'(N_WR + 1)) we_low_cnt <= we_low_cnt + 1'b1;
      end else begin
        we_low_cnt <= '0;
      end
      if (!mem_oe_n_o) quiet_cnt <= '0;
      else if (quiet_cnt != TRN_W'(N_TURN)) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce1_n_o && !mem_ce2_o && mem_we_n_o && mem_oe_n_o)); // R2
  AST_WRITE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce1_n_o && mem_ce2_o && mem_oe_n_o && mem_dq_oe_o)); // R4
  AST_WRITE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> we_low_cnt == WLC_W'(N_WR)); // R4
  AST_ADDR_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_o != $past(mem_addr_o)) |-> $past(mem_we_n_o)); // R5
  AST_ADDR_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && !$past(mem_we_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_io))); // R5
  AST_HOLD_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && mem_ce1_n_o && !mem_ce2_o)); // R6
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> quiet_cnt >= TRN_W'(N_TURN)); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o); // R10
  AST_READ_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_n_o && !$past(mem_oe_n_o)) |-> $stable(mem_addr_o)); // R11
endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int unsigned PER_PS = 8000;
  function automatic int ceil1(int t);
    int c;
    c = (t + PER_PS - 1) / PER_PS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int N_RD   = 11; // ceil(85/8)
  localparam int N_WR   = 11; // ceil(85/8)
  localparam int N_TURN = 5;  // ceil(35/8)

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ready, rd_valid, ce1_n, ce2, we_n, oe_n, dq_oe;
  logic [7:0]  rd_data;
  logic [17:0] maddr;
  wire  [7:0]  dq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .mem_addr_o(maddr),
    .mem_ce1_n_o(ce1_n), .mem_ce2_o(ce2), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_dq_io(dq), .mem_dq_oe_o(dq_oe)
  );

  // memory model, 1K deep slice of the array
  logic [7:0] mem [0:1023];
  wire sel    = !ce1_n && ce2;
  wire rd_act = sel && we_n && !oe_n;
  wire wr_act = sel && !we_n;
  assign dq = rd_act ? mem[maddr[9:0]] : 8'bz;
  always @(negedge wr_act) mem[maddr[9:0]] = dq;

  function automatic logic [7:0] init_val(logic [17:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = init_val(18'(i));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus monitors
  int mon_err = 0;
  logic [17:0] prev_addr;
  logic        prev_we_n;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && rd_act) begin
        mon_err++;
        $display("FAIL R10 contention act=1 exp=0");
      end
      if (maddr != prev_addr && !prev_we_n) begin
        mon_err++;
        $display("FAIL R5 addr moved with WE low act=%0h exp=%0h", maddr, prev_addr);
      end
    end
    prev_addr = maddr;
    prev_we_n = we_n;
  end

  task automatic send(input logic we, input logic [17:0] a, input logic [7:0] d);
    bit acc = 0;
    bit r;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!acc) begin
      r = ready;
      @(posedge clk);
      acc = r;
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [17:0] a, input logic [7:0] exp);
    int lat = 1, n_oe = 0;
    bit addr_ok = 1;
    send(1'b0, a, 8'h00);
    while (!rd_valid && lat < 40) begin
      if (!oe_n && !ce1_n && ce2 && we_n) n_oe++;
      if (!oe_n && maddr != a) addr_ok = 0;
      @(negedge clk);
      lat++;
    end
    chk(lat == N_RD + 1, "R3 read strobe latency", lat, N_RD + 1);
    chk(n_oe == N_RD, "R3 read window cycles", n_oe, N_RD);
    chk(rd_data == exp, "R3 read data", rd_data, exp);
    chk(addr_ok, "R11 read address", maddr, a);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [7:0] d,
                          input bit scramble, output int wait_c);
    int low = 0;
    bit ok = 1;
    send(1'b1, a, d);
    if (scramble) begin
      req_addr = ~a; req_wdata = ~d; req_we = 1'b0;
    end
    wait_c = 0;
    while (we_n && wait_c < 40) begin
      if (dq_oe || !ce1_n) ok = 0;
      @(negedge clk);
      wait_c++;
    end
    while (!we_n && low < 40) begin
      if (ce1_n || !ce2 || !oe_n || !dq_oe || maddr != a || dq != d) ok = 0;
      @(negedge clk);
      low++;
    end
    chk(low == N_WR, "R4 write pulse cycles", low, N_WR);
    chk(ok, "R4 R11 write window pins", maddr, a);
    chk(dq_oe && dq == d && ce1_n && !ce2, "R6 hold after write end", dq_oe, 1);
    @(negedge clk);
    chk(!dq_oe && ready, "R6 drivers released", dq_oe, 0);
  endtask

  task automatic t_reset;
    chk(ce1_n && !ce2 && we_n && oe_n && !dq_oe, "R1 pins in reset", {ce1_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !rd_valid, "R1 ready after reset", {ready, rd_valid}, 2'b10);
    chk(ce1_n && !ce2 && we_n && oe_n && !dq_oe, "R2 idle deselect", {ce1_n, ce2}, 2'b10);
  endtask

  task automatic t_counts;
    chk(ceil1(85000) == N_RD, "R9 read count", ceil1(85000), N_RD);
    chk(ceil1(35000) == N_TURN, "R9 turn count", ceil1(35000), N_TURN);
    chk(ceil1(0) == 1, "R9 floor of one", ceil1(0), 1);
  endtask

  task automatic t_basic;
    int w;
    do_read(18'h2_0013, init_val(18'h2_0013));
    @(negedge clk);
    chk(!rd_valid, "R3 strobe one cycle", rd_valid, 0);
    repeat (8) @(negedge clk);
    do_write(18'h3_FC05, 8'hC3, 1'b0, w);
    chk(w == 0, "R7 write with no recent read", w, 0);
    do_write(18'h0_0206, 8'h1E, 1'b0, w);
    chk(w == 0, "R7 back to back writes", w, 0);
    do_read(18'h3_FC05, 8'hC3);
    repeat (3) @(negedge clk);
    do_read(18'h0_0206, 8'h1E);
  endtask

  task automatic t_turnaround;
    int w;
    do_read(18'h1_0042, init_val(18'h1_0042));
    do_write(18'h1_0042, 8'h99, 1'b0, w);
    chk(w == N_TURN - 1, "R7 turnaround wait", w, N_TURN - 1);
    do_read(18'h1_0042, 8'h99);
  endtask

  task automatic t_ignored;
    int w;
    do_write(18'h1_0100, 8'h3C, 1'b1, w);
    chk(ready, "R8 idle after write", ready, 1);
    do_read(18'h1_0100, 8'h3C);
    do_read(~18'h1_0100, init_val(~18'h1_0100));
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(ce1_n && !ce2 && !rd_valid, "R8 no request without valid", ce1_n, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_counts();
    t_basic();
    t_turnaround();
    t_ignored();
    chk(mon_err == 0, "R5 R10 bus monitors", mon_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule